// File: doc/BRIEF.md
# 1-Wire Bridge Command Decoder

This block is the device-side command processor of a host-to-1-Wire bridge. A host port, already reduced to byte level, delivers command writes (an opcode, a flag saying whether a parameter byte came with it, and the parameter) and read requests. The block holds the status, data, configuration and channel registers. A read pointer decides which of them a read returns. No read carries an address: each accepted command moves the pointer implicitly.

Commands that act on the 1-Wire bus become a one-cycle start strobe with an operation code, a write byte and a single direction/bit value, sent to a downstream slot engine. The engine answers with a done pulse and result bits. These bits are merged into the status and data registers. The block also performs device reset and selects one of up to eight channels. Channel selection uses coded write bytes and coded readback bytes.

Top module: `owb_cmd_decoder`

## Requirements
- R1: After rst_n is released, or after an accepted device-reset command (opcode 0xF0), the status byte reads 0x18 when the line input is high, the pointer selects status, the configuration reads 0x00, the channel index is 0, the data register is 0x00 and eng_start stays low.
- R2: Opcode 0xE1 with parameter 0xF0, 0xE1, 0xD2 or 0xC3 points reads at status, data, channel or configuration respectively; any other parameter is ignored. A valid configuration write leaves the pointer on configuration, a valid channel select leaves it on channel, and every other accepted command leaves it on status. rd_valid and rd_data answer rd_req one cycle later.
- R3: A configuration write (opcode 0xD2) takes effect only if parameter bits 7:4 equal the inverse of bits 3:0. Otherwise the configuration and the pointer keep their values. A configuration read returns zero in bits 7:4 and the stored value in bits 3:0 (bit 3 speed, bit 2 strong pull-up, bit 1 presence masking, bit 0 active pull-up).
- R4: Channel select (opcode 0xC3) maps the write bytes 0xF0, 0xE1, 0xD2, 0xC3, 0xB4, 0xA5, 0x96, 0x87 to channels 0..7. Reading the channel register returns 0xB8, 0xB1, 0xAA, 0xA3, 0x9C, 0x95, 0x8E, 0x87 for channels 0..7. Any other byte, or a channel at or above NUM_CH, is ignored.
- R5: The bus opcodes 0xB4 bus reset, 0x87 single bit, 0xA5 write byte, 0x96 read byte and 0x78 triplet raise eng_start for one cycle, in the cycle after the command. eng_op takes the codes 1, 2, 3, 4, 5 in that order, eng_wbyte carries the parameter and eng_bit carries parameter bit 7. Status bit 0 (busy) is then set until eng_done.
- R6: A bus opcode that arrives while busy is set is discarded, with no start strobe and no pointer change. This also applies when eng_done arrives in that same cycle.
- R7: On eng_done while busy, the operation that is running updates the status bits. Bus reset updates bit 1 (presence) and bit 2 (short). Single bit updates bit 5. Triplet updates bits 5, 6 and 7. Read byte loads eng_rdata into the data register.
- R8: Status bit 4 is set by either reset and is cleared by a valid configuration write.
- R9: Configuration bit 2 clears when a bus operation completes. A valid configuration write in the same cycle as that completion takes priority.
- R10: eng_done while busy is clear leaves the status and data registers unchanged.
- R11: Status bit 3 follows the ow_line input.
- R12: eng_chan shows the selected channel index and eng_cfg shows the configuration nibble.
- R13: Opcodes 0xE1, 0xC3, 0xD2, 0x87, 0xA5 and 0x78 are ignored when cmd_has_param is low. Unknown opcodes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_code | input | 8 | Opcode |
| cmd_has_param | input | 1 | A parameter byte accompanies the opcode |
| cmd_param | input | 8 | Parameter byte |
| rd_req | input | 1 | Read request |
| rd_valid | output | 1 | Read data valid, one cycle after rd_req |
| rd_data | output | 8 | Register selected by the pointer |
| eng_start | output | 1 | One-cycle start of a bus operation |
| eng_op | output | 3 | Operation code 1..5 |
| eng_wbyte | output | 8 | Byte to write |
| eng_bit | output | 1 | Bit value or triplet direction |
| eng_chan | output | CH_W | Selected channel index |
| eng_cfg | output | 4 | Configuration nibble |
| eng_done | input | 1 | Operation complete |
| eng_ppd | input | 1 | Presence detected |
| eng_sd | input | 1 | Short detected |
| eng_sbr | input | 1 | Single-bit result |
| eng_tsb | input | 1 | Triplet second bit |
| eng_dir | input | 1 | Triplet direction taken |
| eng_rdata | input | 8 | Byte read from the bus |
| ow_line | input | 1 | Live 1-Wire line level |

## Verification
Two collisions can happen in one cycle: a completion from the engine arriving together with a new host command. In the first case a bus reset is running and a single-bit command is driven in the very cycle eng_done pulses. The bench expects no start strobe, because the busy gate uses the registered busy flag, and then expects a clean status with busy cleared. In the second case a write-byte runs with strong pull-up set, and a configuration write that keeps strong pull-up set lands on the completion cycle. The bench reads the configuration back and expects the written value, not the self-cleared one.

// File: rtl/owb_pkg.sv
package owb_pkg;

    localparam logic [7:0] OPC_DEV_RST = 8'hF0;
    localparam logic [7:0] OPC_SET_PTR = 8'hE1;
    localparam logic [7:0] OPC_CHAN    = 8'hC3;
    localparam logic [7:0] OPC_CFG     = 8'hD2;
    localparam logic [7:0] OPC_BUS_RST = 8'hB4;
    localparam logic [7:0] OPC_BIT     = 8'h87;
    localparam logic [7:0] OPC_WBYTE   = 8'hA5;
    localparam logic [7:0] OPC_RBYTE   = 8'h96;
    localparam logic [7:0] OPC_TRIP    = 8'h78;

    localparam logic [7:0] PCODE_STATUS = 8'hF0;
    localparam logic [7:0] PCODE_DATA   = 8'hE1;
    localparam logic [7:0] PCODE_CHAN   = 8'hD2;
    localparam logic [7:0] PCODE_CFG    = 8'hC3;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_DATA   = 2'd1,
        SEL_CHAN   = 2'd2,
        SEL_CFG    = 2'd3
    } rsel_e;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_BUSRST = 3'd1,
        OP_BIT    = 3'd2,
        OP_WBYTE  = 3'd3,
        OP_RBYTE  = 3'd4,
        OP_TRIP   = 3'd5
    } bus_op_e;

    typedef enum logic [2:0] {
        K_NONE   = 3'd0,
        K_DEVRST = 3'd1,
        K_SETPTR = 3'd2,
        K_CHAN   = 3'd3,
        K_CFG    = 3'd4,
        K_BUS    = 3'd5
    } kind_e;

    typedef struct packed {
        kind_e       kind;
        bus_op_e     op;
        logic        ptr_ok;
        rsel_e       ptr;
        logic        cfg_ok;
        logic [3:0]  cfg;
    } dec_t;

    // channel write codes step down by 0x0F from 0xF0
    function automatic logic [7:0] chan_wr_code(input int unsigned idx);
        return 8'(32'hF0 - idx * 32'd15);
    endfunction

    // channel readback codes step down by 0x07 from 0xB8
    function automatic logic [7:0] chan_rd_code(input int unsigned idx);
        return 8'(32'hB8 - idx * 32'd7);
    endfunction

endpackage

// File: rtl/owb_cmd_classify.sv
module owb_cmd_classify
    import owb_pkg::*;
(
    input  logic [7:0] code,
    input  logic       has_param,
    input  logic [7:0] param,
    output dec_t       dec
);

    always_comb begin
        dec        = '0;
        dec.kind   = K_NONE;
        dec.op     = OP_NONE;
        dec.ptr    = SEL_STATUS;
        dec.cfg    = param[3:0];
        dec.cfg_ok = (param[7:4] == ~param[3:0]);
        case (code)
            OPC_DEV_RST: dec.kind = K_DEVRST;
            OPC_SET_PTR: begin
                if (has_param) begin
                    dec.kind = K_SETPTR;
                    case (param)
                        PCODE_STATUS: begin dec.ptr_ok = 1'b1; dec.ptr = SEL_STATUS; end
                        PCODE_DATA:   begin dec.ptr_ok = 1'b1; dec.ptr = SEL_DATA;   end
                        PCODE_CHAN:   begin dec.ptr_ok = 1'b1; dec.ptr = SEL_CHAN;   end
                        PCODE_CFG:    begin dec.ptr_ok = 1'b1; dec.ptr = SEL_CFG;    end
                        default:      dec.ptr_ok = 1'b0;
                    endcase
                end
            end
            OPC_CHAN:    if (has_param) dec.kind = K_CHAN;
            OPC_CFG:     if (has_param) dec.kind = K_CFG;
            OPC_BUS_RST: begin dec.kind = K_BUS; dec.op = OP_BUSRST; end
            OPC_RBYTE:   begin dec.kind = K_BUS; dec.op = OP_RBYTE;  end
            OPC_BIT:     if (has_param) begin dec.kind = K_BUS; dec.op = OP_BIT;   end
            OPC_WBYTE:   if (has_param) begin dec.kind = K_BUS; dec.op = OP_WBYTE; end
            OPC_TRIP:    if (has_param) begin dec.kind = K_BUS; dec.op = OP_TRIP;  end
            default:     dec.kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/owb_chan_codec.sv
module owb_chan_codec
    import owb_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [7:0]    wcode,
    input  logic [CW-1:0] cur_idx,
    output logic          hit,
    output logic [CW-1:0] hit_idx,
    output logic [7:0]    rd_code
);

    logic [NUM_CH-1:0] match;

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_match
        assign match[gi] = (wcode == chan_wr_code(gi));
    end

    always_comb begin
        hit     = |match;
        hit_idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = CW'(i);
        end
        rd_code = chan_rd_code(32'(cur_idx));
    end

endmodule

// File: rtl/owb_read_mux.sv
module owb_read_mux
    import owb_pkg::*;
(
    input  rsel_e      sel,
    input  logic [7:0] status,
    input  logic [7:0] data,
    input  logic [7:0] chan_code,
    input  logic [3:0] cfg,
    output logic [7:0] rd_byte
);

    always_comb begin
        case (sel)
            SEL_STATUS: rd_byte = status;
            SEL_DATA:   rd_byte = data;
            SEL_CHAN:   rd_byte = chan_code;
            default:    rd_byte = {4'h0, cfg};
        endcase
    end

endmodule

// File: rtl/owb_cmd_decoder.sv
module owb_cmd_decoder
    import owb_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [7:0]      cmd_code,
    input  logic            cmd_has_param,
    input  logic [7:0]      cmd_param,
    input  logic            rd_req,
    output logic            rd_valid,
    output logic [7:0]      rd_data,
    output logic            eng_start,
    output logic [2:0]      eng_op,
    output logic [7:0]      eng_wbyte,
    output logic            eng_bit,
    output logic [CH_W-1:0] eng_chan,
    output logic [3:0]      eng_cfg,
    input  logic            eng_done,
    input  logic            eng_ppd,
    input  logic            eng_sd,
    input  logic            eng_sbr,
    input  logic            eng_tsb,
    input  logic            eng_dir,
    input  logic [7:0]      eng_rdata,
    input  logic            ow_line
);

    typedef struct packed {
        rsel_e           ptr;
        logic [3:0]      cfg;
        logic [CH_W-1:0] chan;
        logic [7:0]      data;
        logic            dir;
        logic            tsb;
        logic            sbr;
        logic            rst;
        logic            sd;
        logic            ppd;
        logic            busy;
        bus_op_e         cur_op;
        logic            start;
        logic [7:0]      wbyte;
        logic            wbit;
        logic            rd_valid;
        logic [7:0]      rd_data;
    } st_t;

    localparam st_t ST_RST = '{
        ptr: SEL_STATUS, cfg: 4'h0, chan: '0, data: 8'h00,
        dir: 1'b0, tsb: 1'b0, sbr: 1'b0, rst: 1'b1, sd: 1'b0, ppd: 1'b0,
        busy: 1'b0, cur_op: OP_NONE, start: 1'b0, wbyte: 8'h00, wbit: 1'b0,
        rd_valid: 1'b0, rd_data: 8'h00
    };

    st_t             st_d, st_q;
    dec_t            dec;
    logic            ch_hit;
    logic [CH_W-1:0] ch_idx;
    logic [7:0]      ch_rd_code;
    logic [7:0]      status_byte;
    logic [7:0]      mux_byte;

    owb_cmd_classify u_classify (
        .code      (cmd_code),
        .has_param (cmd_has_param),
        .param     (cmd_param),
        .dec       (dec)
    );

    owb_chan_codec #(.NUM_CH(NUM_CH)) u_chan (
        .wcode   (cmd_param),
        .cur_idx (st_q.chan),
        .hit     (ch_hit),
        .hit_idx (ch_idx),
        .rd_code (ch_rd_code)
    );

    assign status_byte = {st_q.dir, st_q.tsb, st_q.sbr, st_q.rst,
                          ow_line, st_q.sd, st_q.ppd, st_q.busy};

    owb_read_mux u_mux (
        .sel       (st_q.ptr),
        .status    (status_byte),
        .data      (st_q.data),
        .chan_code (ch_rd_code),
        .cfg       (st_q.cfg),
        .rd_byte   (mux_byte)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;

        // completion from the engine
        if (eng_done && st_q.busy) begin
            st_d.busy   = 1'b0;
            st_d.cfg[2] = 1'b0;
            case (st_q.cur_op)
                OP_BUSRST: begin
                    st_d.ppd = eng_ppd;
                    st_d.sd  = eng_sd;
                end
                OP_BIT:   st_d.sbr = eng_sbr;
                OP_TRIP: begin
                    st_d.sbr = eng_sbr;
                    st_d.tsb = eng_tsb;
                    st_d.dir = eng_dir;
                end
                OP_RBYTE: st_d.data = eng_rdata;
                default:  st_d.data = st_q.data;
            endcase
        end

        // host command; applied after completion so a write wins
        if (cmd_valid) begin
            case (dec.kind)
                K_DEVRST: st_d = ST_RST;
                K_SETPTR: if (dec.ptr_ok) st_d.ptr = dec.ptr;
                K_CHAN: begin
                    if (ch_hit) begin
                        st_d.chan = ch_idx;
                        st_d.ptr  = SEL_CHAN;
                    end
                end
                K_CFG: begin
                    if (dec.cfg_ok) begin
                        st_d.cfg = dec.cfg;
                        st_d.rst = 1'b0;
                        st_d.ptr = SEL_CFG;
                    end
                end
                K_BUS: begin
                    if (!st_q.busy) begin
                        st_d.busy   = 1'b1;
                        st_d.cur_op = dec.op;
                        st_d.start  = 1'b1;
                        st_d.wbyte  = cmd_param;
                        st_d.wbit   = cmd_param[7];
                        st_d.ptr    = SEL_STATUS;
                    end
                end
                default: st_d.ptr = st_d.ptr;
            endcase
        end

        st_d.rd_valid = rd_req;
        st_d.rd_data  = rd_req ? mux_byte : st_q.rd_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign rd_valid  = st_q.rd_valid;
    assign rd_data   = st_q.rd_data;
    assign eng_start = st_q.start;
    assign eng_op    = st_q.cur_op;
    assign eng_wbyte = st_q.wbyte;
    assign eng_bit   = st_q.wbit;
    assign eng_chan  = st_q.chan;
    assign eng_cfg   = st_q.cfg;

    // observation points for the bound checker
    logic       obs_busy;
    logic [3:0] obs_cfg;
    logic [5:0] obs_flags;
    logic [7:0] obs_data;
    assign obs_busy  = st_q.busy;
    assign obs_cfg   = st_q.cfg;
    assign obs_flags = {st_q.dir, st_q.tsb, st_q.sbr, st_q.rst, st_q.sd, st_q.ppd};
    assign obs_data  = st_q.data;

endmodule

// File: rtl/owb_cmd_decoder_sva.sv
module owb_cmd_decoder_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [7:0] cmd_code,
    input logic       rd_req,
    input logic       rd_valid,
    input logic       eng_start,
    input logic       eng_done,
    input logic       busy,
    input logic [3:0] cfg,
    input logic [5:0] flags,
    input logic [7:0] data
);

    // R5: a start strobe is always accompanied by the busy flag
    assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> busy);

    // R6: busy gate prevents back-to-back starts
    assert_single_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R2: read data valid only answers a request one cycle earlier
    assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));

    // R9: completion without a coincident config command clears strong pull-up
    assert_spu_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && busy && !(cmd_valid && (cmd_code == 8'hD2 || cmd_code == 8'hF0)))
        |=> !cfg[2]);

    // R10: stray completion while idle changes no result register
    assert_idle_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !busy && !cmd_valid) |=> ($stable(flags) && $stable(data)));

    // R3: configuration only moves on a command or a completion
    assert_cfg_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg) |-> ($past(cmd_valid) || $past(eng_done)));

endmodule

bind owb_cmd_decoder owb_cmd_decoder_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .rd_req    (rd_req),
    .rd_valid  (rd_valid),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .busy      (obs_busy),
    .cfg       (obs_cfg),
    .flags     (obs_flags),
    .data      (obs_data)
);

// File: tb/owb_cmd_decoder_test.sv
`timescale 1ns/1ps
module owb_cmd_decoder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = 8'h00;
    logic       cmd_has_param = 1'b0;
    logic [7:0] cmd_param = 8'h00;
    logic       rd_req = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       eng_start;
    logic [2:0] eng_op;
    logic [7:0] eng_wbyte;
    logic       eng_bit;
    logic [2:0] eng_chan;
    logic [3:0] eng_cfg;
    logic       eng_done = 1'b0;
    logic       eng_ppd = 1'b0, eng_sd = 1'b0, eng_sbr = 1'b0, eng_tsb = 1'b0, eng_dir = 1'b0;
    logic [7:0] eng_rdata = 8'h00;
    logic       ow_line = 1'b1;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] v;

    always #4 clk = ~clk;

    owb_cmd_decoder #(.NUM_CH(8)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_has_param(cmd_has_param), .cmd_param(cmd_param), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_data(rd_data), .eng_start(eng_start), .eng_op(eng_op),
        .eng_wbyte(eng_wbyte), .eng_bit(eng_bit), .eng_chan(eng_chan), .eng_cfg(eng_cfg),
        .eng_done(eng_done), .eng_ppd(eng_ppd), .eng_sd(eng_sd), .eng_sbr(eng_sbr),
        .eng_tsb(eng_tsb), .eng_dir(eng_dir), .eng_rdata(eng_rdata), .ow_line(ow_line)
    );

    // {opcode, parameter, expected readback}
    localparam logic [23:0] VEC [16] = '{
        24'hC3_F0_B8, 24'hC3_E1_B1, 24'hC3_D2_AA, 24'hC3_C3_A3,
        24'hC3_B4_9C, 24'hC3_A5_95, 24'hC3_96_8E, 24'hC3_87_87,
        24'hC3_55_87, 24'hD2_E1_01, 24'hD2_33_01, 24'hD2_5A_0A,
        24'hE1_E1_00, 24'hE1_C3_0A, 24'hE1_77_0A, 24'hE1_F0_08
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic send(input logic [7:0] c, input logic [7:0] p, input logic hp);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = c; cmd_param = p; cmd_has_param = hp;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic read_reg(output logic [7:0] val);
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        val = rd_data;
        n_chk++;
        if (rd_valid !== 1'b1) begin
            n_fail++;
            $display("FAIL R2: rd_valid got %b expected 1", rd_valid);
        end
    endtask

    task automatic finish_op(input logic ppd, input logic sd, input logic sbr,
                             input logic tsb, input logic dir, input logic [7:0] rb);
        @(negedge clk);
        eng_done = 1'b1; eng_ppd = ppd; eng_sd = sd; eng_sbr = sbr;
        eng_tsb = tsb; eng_dir = dir; eng_rdata = rb;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 start idle", {7'd0, eng_start}, 8'h00);
        read_reg(v); check("R1 status after rst_n", v, 8'h18);

        // table walk: R4 channel codes, R3 config, R2 pointer
        for (int i = 0; i < 16; i++) begin
            send(VEC[i][23:16], VEC[i][15:8], 1'b1);
            read_reg(v);
            if (VEC[i][23:16] == 8'hC3)      check("R4 channel table", v, VEC[i][7:0]);
            else if (VEC[i][23:16] == 8'hD2) check("R3 config table", v, VEC[i][7:0]);
            else                             check("R2 pointer table", v, VEC[i][7:0]);
        end

        // known state, then R8
        send(8'hF0, 8'h00, 1'b0);
        read_reg(v); check("R1 status after device reset", v, 8'h18);
        send(8'hD2, 8'hE1, 1'b1);
        send(8'hE1, 8'hF0, 1'b1);
        read_reg(v); check("R8 rst bit cleared", v, 8'h08);

        // R5 bus reset start, busy; R6 discard
        send(8'hB4, 8'h00, 1'b0);
        check("R5 start strobe", {7'd0, eng_start}, 8'h01);
        check("R5 op bus reset", {5'd0, eng_op}, 8'h01);
        read_reg(v); check("R5 busy in status", v, 8'h09);
        send(8'hA5, 8'h42, 1'b1);
        check("R6 discarded while busy", {7'd0, eng_start}, 8'h00);
        finish_op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        read_reg(v); check("R7 presence captured", v, 8'h0A);

        // R7 read byte
        send(8'h96, 8'h00, 1'b0);
        check("R5 op read byte", {5'd0, eng_op}, 8'h04);
        finish_op(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C);
        send(8'hE1, 8'hE1, 1'b1);
        read_reg(v); check("R7 data register", v, 8'h3C);

        // R7 triplet and single bit
        send(8'h78, 8'h80, 1'b1);
        check("R5 triplet bit", {6'd0, eng_bit, eng_start}, 8'h03);
        finish_op(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
        read_reg(v); check("R7 triplet status", v, 8'hAA);
        send(8'h87, 8'h00, 1'b1);
        check("R5 single bit value", {5'd0, eng_op[1:0], eng_bit}, 8'h04);
        finish_op(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        read_reg(v); check("R7 single bit status", v, 8'h8A);

        // R10 stray completion
        finish_op(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'hFF);
        read_reg(v); check("R10 status unchanged", v, 8'h8A);
        send(8'hE1, 8'hE1, 1'b1);
        read_reg(v); check("R10 data unchanged", v, 8'h3C);

        // R9 strong pull-up self clear
        send(8'hD2, 8'hA5, 1'b1);
        read_reg(v); check("R9 spu set", v, 8'h05);
        send(8'hA5, 8'h99, 1'b1);
        check("R5 write byte value", eng_wbyte, 8'h99);
        finish_op(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        send(8'hE1, 8'hC3, 1'b1);
        read_reg(v); check("R9 spu cleared", v, 8'h01);

        // collision 1: bus command in completion cycle is discarded (R6)
        send(8'hB4, 8'h00, 1'b0);
        @(negedge clk);
        eng_done = 1'b1; eng_ppd = 1'b1; eng_sd = 1'b0;
        cmd_valid = 1'b1; cmd_code = 8'h87; cmd_param = 8'h80; cmd_has_param = 1'b1;
        @(negedge clk);
        eng_done = 1'b0; cmd_valid = 1'b0;
        check("R6 discard in done cycle", {7'd0, eng_start}, 8'h00);
        read_reg(v); check("R6 idle after collision", v, 8'h8A);

        // collision 2: config write wins over self clear (R9)
        send(8'hD2, 8'hA5, 1'b1);
        send(8'hA5, 8'h11, 1'b1);
        @(negedge clk);
        eng_done = 1'b1;
        cmd_valid = 1'b1; cmd_code = 8'hD2; cmd_param = 8'hB4; cmd_has_param = 1'b1;
        @(negedge clk);
        eng_done = 1'b0; cmd_valid = 1'b0;
        read_reg(v); check("R9 write wins", v, 8'h04);

        // R11 line level
        ow_line = 1'b0;
        send(8'hE1, 8'hF0, 1'b1);
        read_reg(v); check("R11 line low", v, 8'h82);
        ow_line = 1'b1;

        // R13 missing parameter
        send(8'hD2, 8'hE1, 1'b0);
        read_reg(v); check("R13 no-param ignored", v, 8'h8A);
        send(8'h5B, 8'h00, 1'b1);
        read_reg(v); check("R13 unknown opcode", v, 8'h8A);

        // R12 engine-facing registers
        send(8'hC3, 8'hA5, 1'b1);
        check("R12 eng_chan", {5'd0, eng_chan}, 8'h05);
        check("R12 eng_cfg", {4'd0, eng_cfg}, 8'h04);

        // R1 device reset restores everything
        send(8'hF0, 8'h00, 1'b0);
        read_reg(v); check("R1 status", v, 8'h18);
        check("R1 channel index", {5'd0, eng_chan}, 8'h00);
        send(8'hE1, 8'hC3, 1'b1);
        read_reg(v); check("R1 config", v, 8'h00);
        send(8'hE1, 8'hD2, 1'b1);
        read_reg(v); check("R1 channel code", v, 8'hB8);
        send(8'hE1, 8'hE1, 1'b1);
        read_reg(v); check("R1 data", v, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule